// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial instruction decoder of a small serial-access nonvolatile memory model. When the decoder has a complete and correctly counted write, erase, erase-all or write-all instruction, it pulses a commit strobe at the moment chip select drops. The controller latches the request and runs an internal cycle of a fixed number of system clocks. At the end of that cycle it applies the change to a register-based storage array. While the cycle runs it refuses every further commit. A single-word write first clears its location to all ones halfway through the cycle and stores the new value at the end.

The busy flag is exported so the decoder can gate itself. The controller also drives the serial data-out line with a status level. After chip select has been low long enough and is raised again, the line shows 0 while the cycle is running and 1 once it has finished. The ready level remains until chip select is lowered or the decoder reports a fresh start bit. A read port returns the stored word at any address combinationally. It is the path the read instruction uses, and the testbench uses it as well.

Top module: `pgm_cycle_ctrl`

## Requirements
- R1: After reset, every word of the array reads all ones, `busy_o` is 0 and `sdo_en_o` is 0.
- R2: A commit with `commit_ok_i`=1 while idle makes `busy_o` 1 from the next clock edge for exactly CYCLE_CLKS cycles.
- R3: A commit with `commit_ok_i`=0 starts no cycle and changes no word of the array.
- R4: For a single-word write (`op_i`=0), the addressed word reads all ones ERASE_CLKS edges after the commit edge and holds the new data once `busy_o` falls. No other word changes.
- R5: A single-word erase (`op_i`=1) sets the addressed word to all ones on the edge where `busy_o` falls.
- R6: Erase-all (`op_i`=2) leaves the array untouched until the final edge of the cycle, then every word reads all ones.
- R7: Write-all (`op_i`=3) leaves the array untouched until the final edge of the cycle, then every word holds the supplied data.
- R8: A commit that arrives while busy is ignored. The running cycle keeps its length, and the second request's location is not changed.
- R9: Chip select is raised after at least MIN_DESEL low cycles while busy. From the next edge, `sdo_en_o`=1 and `sdo_o`=0. A start bit seen during that time has no effect on the status.
- R10: After the cycle ends with status shown, `sdo_o`=1 and `sdo_en_o`=1 while chip select stays high. One edge after chip select drops, `sdo_en_o` is 0, and the consumed ready is not shown on the next select.
- R11: A start bit while idle and ready is shown clears the ready indication, so `sdo_en_o` is 0 from the next edge.
- R12: A chip select rise that follows fewer than MIN_DESEL low cycles shows no status for that whole select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select level, synchronous to clk |
| start_bit_i | input | 1 | One-cycle pulse: decoder saw a start bit |
| commit_i | input | 1 | One-cycle commit strobe at chip select fall |
| commit_ok_i | input | 1 | Instruction complete and clock count matched |
| op_i | input | 2 | 0 write, 1 erase, 2 erase-all, 3 write-all |
| addr_i | input | ADDR_W | Target word address |
| data_i | input | DATA_W | Data for write and write-all |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | DATA_W | Stored word at rd_addr_i |
| busy_o | output | 1 | Internal cycle in progress |
| sdo_o | output | 1 | Serial status level (0 busy, 1 ready) |
| sdo_en_o | output | 1 | Status line is being driven |

## Verification
If the commit strobe is captured on edge E, `busy_o` is high on the edges E through E+CYCLE_CLKS-1. The write pre-clear is visible after edge E+ERASE_CLKS, and the final array update and ready level appear after edge E+CYCLE_CLKS. Status changes caused by chip select or a start bit appear one edge after the edge that captures them. Each stimulus task returns the number of the edge that captures it. The driver then queues expected values stamped with the exact due edge, and the monitor compares them at the falling clock edge that follows. The checks include the last cycle before each due edge, so an update that arrives early is caught as well as one that arrives late.

// File: rtl/pgm_cycle_pkg.sv
`timescale 1ns/1ps
package pgm_cycle_pkg;
    typedef enum logic [1:0] {
        OP_WRITE     = 2'd0,
        OP_ERASE     = 2'd1,
        OP_ERASE_ALL = 2'd2,
        OP_WRITE_ALL = 2'd3
    } pgm_op_e;
endpackage

// File: rtl/pgm_cycle_timer.sv
`timescale 1ns/1ps
module pgm_cycle_timer #(
    parameter int CYCLE_CLKS = 40,
    parameter int ERASE_CLKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o,
    output logic erase_pt_o,
    output logic finish_o
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CYCLE_CLKS - 1);
    localparam logic [CNT_W-1:0] ERASE_CNT = CNT_W'(ERASE_CLKS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (launch_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign erase_pt_o = st_q.busy && (st_q.cnt == ERASE_CNT);
    assign finish_o   = st_q.busy && (st_q.cnt == LAST_CNT);

    // busy may only drop after the full count has elapsed
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(st_q.cnt) == LAST_CNT);

    // a launch request during a cycle neither restarts nor stalls the count
    assert_no_relaunch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !finish_o) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/pgm_cycle_array.sv
`timescale 1ns/1ps
module pgm_cycle_array
    import pgm_cycle_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pgm_op_e           op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              erase_pt_i,
    input  logic              finish_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } arr_t;

    arr_t st_d, st_q;
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = (addr_i == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (finish_i) begin
                case (op_i)
                    OP_WRITE:     if (hit[i]) st_d.mem[i] = data_i;
                    OP_ERASE:     if (hit[i]) st_d.mem[i] = ONES;
                    OP_ERASE_ALL: st_d.mem[i] = ONES;
                    OP_WRITE_ALL: st_d.mem[i] = data_i;
                    default:      st_d.mem[i] = st_q.mem[i];
                endcase
            end else if (erase_pt_i && op_i == OP_WRITE && hit[i]) begin
                st_d.mem[i] = ONES;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.mem[rd_addr_i];

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_pt_i || finish_i) |=> $stable(st_q));

    assert_pre_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_pt_i && op_i == OP_WRITE) |=> st_q.mem[$past(addr_i)] == ONES);

    assert_erase_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && op_i == OP_ERASE_ALL) |=> &st_q);

    assert_write_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && op_i == OP_WRITE_ALL) |=> st_q.mem[DEPTH-1] == $past(data_i));
endmodule

// File: rtl/pgm_cycle_status.sv
`timescale 1ns/1ps
module pgm_cycle_status #(
    parameter int MIN_DESEL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic start_bit_i,
    input  logic busy_i,
    input  logic finish_i,
    output logic sdo_o,
    output logic sdo_en_o
);
    localparam int LC_W = $clog2(MIN_DESEL + 1);
    localparam logic [LC_W-1:0] MIN_C = LC_W'(MIN_DESEL);

    typedef struct packed {
        logic            cs_prev;
        logic [LC_W-1:0] low_cnt;
        logic            show;
        logic            rdy_pend;
    } sts_t;

    sts_t st_d, st_q;
    logic cs_rise;

    assign cs_rise = cs_i && !st_q.cs_prev;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_i;

        if (cs_i)                  st_d.low_cnt = '0;
        else if (st_q.low_cnt != MIN_C) st_d.low_cnt = st_q.low_cnt + LC_W'(1);

        if (!cs_i)        st_d.show = 1'b0;
        else if (cs_rise) st_d.show = (st_q.low_cnt >= MIN_C);

        if (finish_i)
            st_d.rdy_pend = 1'b1;
        else if (!busy_i && ((st_q.show && !cs_i) || start_bit_i))
            st_d.rdy_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_en_o = st_q.show && (busy_i || st_q.rdy_pend);
    assign sdo_o    = sdo_en_o && !busy_i;

    assert_desel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !sdo_en_o);

    assert_status_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.show) |-> $past(st_q.low_cnt) >= MIN_C);

    // a start bit cannot withdraw the busy indication
    assert_start_ignored_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en_o && busy_i && cs_i && start_bit_i && !finish_i) |=> sdo_en_o);
endmodule

// File: rtl/pgm_cycle_ctrl.sv
`timescale 1ns/1ps
module pgm_cycle_ctrl
    import pgm_cycle_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 40,
    parameter int ERASE_CLKS = CYCLE_CLKS / 2,
    parameter int MIN_DESEL  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              start_bit_i,
    input  logic              commit_i,
    input  logic              commit_ok_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              sdo_o,
    output logic              sdo_en_o
);
    typedef struct packed {
        pgm_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    req_t req_d, req_q;
    logic launch, busy, erase_pt, finish;

    assign launch = commit_i && commit_ok_i && !busy;

    always_comb begin
        req_d = req_q;
        if (launch) begin
            req_d.op   = pgm_op_e'(op_i);
            req_d.addr = addr_i;
            req_d.data = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    pgm_cycle_timer #(
        .CYCLE_CLKS (CYCLE_CLKS),
        .ERASE_CLKS (ERASE_CLKS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .busy_o     (busy),
        .erase_pt_o (erase_pt),
        .finish_o   (finish)
    );

    pgm_cycle_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (req_q.op),
        .addr_i     (req_q.addr),
        .data_i     (req_q.data),
        .erase_pt_i (erase_pt),
        .finish_i   (finish),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o)
    );

    pgm_cycle_status #(
        .MIN_DESEL (MIN_DESEL)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs_i),
        .start_bit_i (start_bit_i),
        .busy_i      (busy),
        .finish_i    (finish),
        .sdo_o       (sdo_o),
        .sdo_en_o    (sdo_en_o)
    );

    assign busy_o = busy;

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && commit_ok_i && !busy_o) |=> busy_o);

    assert_rejected_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !commit_ok_i && !busy_o) |=> !busy_o);

    assert_request_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish) |=> $stable(req_q));
endmodule

// File: tb/pgm_cycle_ctrl_tb.sv
`timescale 1ns/10ps
module pgm_cycle_ctrl_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CYC    = 40;
    localparam int ERS    = 20;
    localparam int MIND   = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam int K_BUSY = 0, K_EN = 1, K_SDO = 2, K_MEM = 3, K_ALL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0, start_bit_i = 1'b0, commit_i = 1'b0, commit_ok_i = 1'b0;
    logic [1:0] op_i = '0;
    logic [ADDR_W-1:0] addr_i = '0, rd_addr_i = '0;
    logic [DATA_W-1:0] data_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic busy_o, sdo_o, sdo_en_o;

    always #4 clk = ~clk;

    pgm_cycle_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYC),
        .ERASE_CLKS(ERS), .MIN_DESEL(MIND)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .start_bit_i(start_bit_i),
        .commit_i(commit_i), .commit_ok_i(commit_ok_i), .op_i(op_i),
        .addr_i(addr_i), .data_i(data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
    );

    typedef struct {
        int    due;
        int    kind;
        int    addr;
        int    exp;
        string req;
    } exp_t;

    exp_t sbq[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int due, int kind, int addr, int val, string req);
        exp_t it;
        it.due = due; it.kind = kind; it.addr = addr; it.exp = val; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic check_item(exp_t it);
        int act;
        act = 0;
        case (it.kind)
            K_BUSY: act = int'(busy_o);
            K_EN:   act = int'(sdo_en_o);
            K_SDO:  act = int'(sdo_o);
            K_MEM: begin
                rd_addr_i = ADDR_W'(it.addr);
                #0.05;
                act = int'(rd_data_o);
            end
            default: begin
                act = it.exp;
                for (int a = 0; a < DEPTH; a++) begin
                    rd_addr_i = ADDR_W'(a);
                    #0.05;
                    if (int'(rd_data_o) != it.exp) act = int'(rd_data_o);
                end
            end
        endcase
        n_chk++;
        if (act != it.exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d kind %0d addr %0d: actual %0h expected %0h",
                     it.req, cyc, it.kind, it.addr, act, it.exp);
        end
    endtask

    // monitor: compares queued expectations when their due edge has passed
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].due == cyc) begin
                    check_item(sbq[i]);
                    sbq.delete(i);
                end
            end
        end
    end

    // all driver tasks start and end at a falling edge
    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic commit(int op, int addr, int data, bit ok, output int e0);
        commit_i = 1'b1; commit_ok_i = ok; op_i = 2'(op);
        addr_i = ADDR_W'(addr); data_i = DATA_W'(data);
        e0 = cyc + 1;
        @(negedge clk);
        commit_i = 1'b0; commit_ok_i = 1'b0;
    endtask

    task automatic set_cs(bit v, output int e);
        cs_i = v;
        e = cyc + 1;
        @(negedge clk);
    endtask

    task automatic pulse_start(output int e);
        start_bit_i = 1'b1;
        e = cyc + 1;
        @(negedge clk);
        start_bit_i = 1'b0;
    endtask

    initial begin
        int e0, e1, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_at(cyc, K_BUSY, 0, 0, "R1");
        expect_at(cyc, K_EN, 0, 0, "R1");
        expect_at(cyc, K_ALL, 0, 'hFF, "R1");
        @(negedge clk);

        // rejected commit
        commit(0, 5, 'h3C, 1'b0, e0);
        expect_at(e0 + 1, K_BUSY, 0, 0, "R3");
        expect_at(e0 + CYC + 1, K_MEM, 5, 'hFF, "R3");
        wait_until(e0 + CYC + 3);

        // first write
        commit(0, 5, 'h3C, 1'b1, e0);
        expect_at(e0, K_BUSY, 0, 1, "R2");
        expect_at(e0 + CYC - 1, K_BUSY, 0, 1, "R2");
        expect_at(e0 + CYC - 1, K_MEM, 5, 'hFF, "R4");
        expect_at(e0 + CYC, K_BUSY, 0, 0, "R2");
        expect_at(e0 + CYC, K_MEM, 5, 'h3C, "R4");
        expect_at(e0 + CYC, K_MEM, 6, 'hFF, "R4");
        wait_until(e0 + CYC + 3);

        // second write shows the automatic pre-clear; a commit while busy is dropped
        commit(0, 5, 'h81, 1'b1, e0);
        expect_at(e0 + ERS - 1, K_MEM, 5, 'h3C, "R4");
        expect_at(e0 + ERS, K_MEM, 5, 'hFF, "R4");
        expect_at(e0 + CYC, K_MEM, 5, 'h81, "R4");
        wait_until(e0 + 4);
        commit(0, 9, 'h00, 1'b1, e1);
        expect_at(e0 + CYC, K_BUSY, 0, 0, "R8");
        expect_at(e0 + CYC + 2, K_BUSY, 0, 0, "R8");
        expect_at(e0 + CYC + 2, K_MEM, 9, 'hFF, "R8");
        wait_until(e0 + CYC + 4);

        // erase with busy then ready shown on the data-out line
        commit(1, 5, 'h00, 1'b1, e0);
        expect_at(e0 + CYC - 1, K_MEM, 5, 'h81, "R5");
        expect_at(e0 + CYC, K_MEM, 5, 'hFF, "R5");
        wait_until(e0 + 2);
        set_cs(1'b1, r);
        expect_at(r, K_EN, 0, 1, "R9");
        expect_at(r, K_SDO, 0, 0, "R9");
        expect_at(e0 + CYC, K_EN, 0, 1, "R10");
        expect_at(e0 + CYC, K_SDO, 0, 1, "R10");
        expect_at(e0 + CYC + 3, K_SDO, 0, 1, "R10");
        wait_until(e0 + CYC + 4);
        set_cs(1'b0, r);
        expect_at(r, K_EN, 0, 0, "R10");
        wait_until(r + 5);
        set_cs(1'b1, r);
        expect_at(r, K_EN, 0, 0, "R10");
        wait_until(r + 2);
        set_cs(1'b0, r);
        wait_until(r + 5);

        // write-all: atomic at the last edge; start bit ignored while busy; short deselect
        commit(3, 0, 'h5A, 1'b1, e0);
        expect_at(e0 + CYC - 1, K_ALL, 0, 'hFF, "R7");
        expect_at(e0 + CYC, K_ALL, 0, 'h5A, "R7");
        wait_until(e0 + 3);
        set_cs(1'b1, r);
        expect_at(r, K_EN, 0, 1, "R9");
        wait_until(e0 + 5);
        pulse_start(r);
        expect_at(r + 1, K_EN, 0, 1, "R9");
        expect_at(r + 1, K_SDO, 0, 0, "R9");
        wait_until(e0 + 8);
        set_cs(1'b0, r);
        set_cs(1'b1, r);
        expect_at(r, K_EN, 0, 0, "R12");
        expect_at(r + 2, K_EN, 0, 0, "R12");
        wait_until(e0 + 14);
        set_cs(1'b0, r);
        wait_until(e0 + CYC + 3);

        // erase-all, then a start bit consumes the ready indication
        commit(2, 0, 'h00, 1'b1, e0);
        expect_at(e0 + CYC - 1, K_ALL, 0, 'h5A, "R6");
        expect_at(e0 + CYC, K_ALL, 0, 'hFF, "R6");
        wait_until(e0 + CYC + 2);
        set_cs(1'b1, r);
        expect_at(r, K_EN, 0, 1, "R10");
        expect_at(r, K_SDO, 0, 1, "R10");
        wait_until(r + 2);
        pulse_start(r);
        expect_at(r, K_EN, 0, 0, "R11");
        expect_at(r + 2, K_EN, 0, 0, "R11");
        wait_until(r + 4);
        cs_i = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        if (sbq.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule